// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Flag Unit

This block provides the interrupt logic for one general-purpose input port of up to eight pins. Every pin input is synchronised into the clock domain. The block then watches each pin for a transition in the direction that software chose for that pin: a low-to-high or a high-to-low change. When the chosen transition arrives, the pin's sticky pending flag is set. It stays set until software writes a one to that flag's bit position.

A per-pin enable mask gates the flags. The OR of all enabled pending flags forms a single interrupt request line toward the interrupt controller. Flags record events whether or not they are enabled. Software should therefore clear stale flags before it opens the mask. Software reaches the registers through a simple bus with an address, a write strobe, write data and combinational read data. The parameter `PIN_COUNT` sets how many pins exist. Register bits above that count are reserved: they read as zero and ignore writes.

Each implemented pin has a two-state flag machine. In `FLAG_IDLE` the machine takes the *set* transition to `FLAG_PENDING` when a selected edge is detected. In `FLAG_PENDING` it takes the *clear* transition back to `FLAG_IDLE` on a write-one-to-clear, but only if no new edge arrives in the same cycle. Otherwise it *holds* its state.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the enable register, the edge-select register and the flag register all read 0, and `irq_req` is low.
- R2: With a pin's edge-select bit at 0, a low-to-high change on the pin sets its flag, and a high-to-low change does not.
- R3: With a pin's edge-select bit at 1, a high-to-low change on the pin sets its flag, and a low-to-high change does not.
- R4: Writing to the flag register at offset 7 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R5: `irq_req` equals the OR over all pins of (flag AND enable bit), with no added clock delay. Setting an enable bit while its flag is already 1 raises `irq_req` in the next cycle after the write.
- R6: A flag is set by its selected edge even when its enable bit is 0, and `irq_req` stays low in that case.
- R7: Register bits at positions `PIN_COUNT` and above read 0 in the enable, edge-select and flag registers, and writes to them have no effect.
- R8: If a clear write and a new selected edge hit the same flag in the same cycle, the flag remains 1.
- R9: Changing an edge-select bit while the pin is steady never sets the flag.
- R10: The enable mask is at offset 5, the edge-select register at offset 6 and the flag register at offset 7. Bit n of each register belongs to pin n. All other offsets read 0, and writes to them change nothing.
- R11: A pin change that is applied between two clock edges becomes visible in the flag register after the third rising clock edge that follows. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, applied at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| irq_req | output | 1 | Interrupt request to the interrupt controller |

## Verification
The bench builds the block with `PIN_COUNT` = 6 and the default 4-bit address. This configuration has both implemented pins and reserved bit positions. It also lets the bench visit every register offset.

For each of the eight bit positions, the bench sweeps both polarities and both transition directions. It then sweeps all 256 enable-mask values against a fixed flag pattern. Together these cover every pairing of flag and enable, and they show that the reserved bits and unused offsets stay inert. Directed cases check the clear-versus-edge collision cycle, polarity changes on a steady pin, and the exact synchroniser latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_W    = 8;
    localparam int OFF_EN   = 5;
    localparam int OFF_SEL  = 6;
    localparam int OFF_FLAG = 7;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic fall_sel,
    output logic edge_hit
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Polarity only picks which of two transitions counts; a steady level
    // gives sync_q == prev_q, so a polarity change alone cannot fire.
    always_comb begin
        if (fall_sel) edge_hit = prev_q & ~sync_q;
        else          edge_hit = ~prev_q & sync_q;
    end

endmodule

// File: rtl/gpio_flag_fsm.sv
module gpio_flag_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic clr_req,
    output logic flag_o
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (edge_hit)              state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_req && !edge_hit)  state_d = FLAG_IDLE;
            default:                                 state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_PENDING);
    end

    // R8: an edge always leaves the flag pending, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (state_q == FLAG_PENDING));

    // R4: a clear without a competing edge returns the flag to idle
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLAG_PENDING && clr_req && !edge_hit) |=> (state_q == FLAG_IDLE));

    // R2: with neither event the flag keeps its value
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_hit && !clr_req) |=> $stable(state_q));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [PIN_COUNT-1:0] flag_vec,
    output logic [PIN_COUNT-1:0] en_q,
    output logic [PIN_COUNT-1:0] sel_q,
    output logic [PIN_COUNT-1:0] clr_vec,
    output logic [REG_W-1:0]     bus_rdata
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_SEL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);

    logic [PIN_COUNT-1:0] wr_bits;
    logic                 wr_en;
    logic                 wr_sel;

    assign wr_bits = bus_wdata[PIN_COUNT-1:0];
    assign wr_en   = bus_we && (bus_addr == A_EN);
    assign wr_sel  = bus_we && (bus_addr == A_SEL);
    assign clr_vec = (bus_we && (bus_addr == A_FLAG)) ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (wr_en)  en_q  <= wr_bits;
            if (wr_sel) sel_q <= wr_bits;
        end
    end

    always_comb begin
        case (bus_addr)
            A_EN:    bus_rdata = REG_W'(en_q);
            A_SEL:   bus_rdata = REG_W'(sel_q);
            A_FLAG:  bus_rdata = REG_W'(flag_vec);
            default: bus_rdata = '0;
        endcase
    end

    // R10: enable write lands at offset 5
    a_r10_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN) |=> (en_q == $past(bus_wdata[PIN_COUNT-1:0])));

    // R10: edge-select write lands at offset 6
    a_r10_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SEL) |=> (sel_q == $past(bus_wdata[PIN_COUNT-1:0])));

    // R10: writes elsewhere leave both control registers alone
    a_r10_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == A_EN || bus_addr == A_SEL)) |=> ($stable(en_q) && $stable(sel_q)));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic                 irq_req
);

    logic [PIN_COUNT-1:0] en_q;
    logic [PIN_COUNT-1:0] sel_q;
    logic [PIN_COUNT-1:0] clr_vec;
    logic [PIN_COUNT-1:0] edge_vec;
    logic [PIN_COUNT-1:0] flag_vec;

    gpio_irq_regs #(
        .PIN_COUNT (PIN_COUNT),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .flag_vec  (flag_vec),
        .en_q      (en_q),
        .sel_q     (sel_q),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        gpio_pin_sync u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[i]),
            .fall_sel  (sel_q[i]),
            .edge_hit  (edge_vec[i])
        );

        gpio_flag_fsm u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_hit (edge_vec[i]),
            .clr_req  (clr_vec[i]),
            .flag_o   (flag_vec[i])
        );
    end

    assign irq_req = |(flag_vec & en_q);

    // R6: a detected edge latches its flag regardless of the enable mask
    a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_vec) |=> ((flag_vec & $past(edge_vec)) == $past(edge_vec)));

    // R5: no request can be raised with the whole mask closed
    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|en_q));

    // R1: everything starts idle straight after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (flag_vec == '0 && en_q == '0 && sel_q == '0));

endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 6;
    localparam int AW         = 4;
    localparam logic [7:0] IMPL = 8'h3F;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [7:0]     pins = '0;
    logic           irq_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq #(.PIN_COUNT(NPIN), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins[NPIN-1:0]),
        .irq_req   (irq_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        bus_addr = AW'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] exp_flag;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset values
        rd(5, 8'h00, "R1 enable after reset");
        rd(6, 8'h00, "R1 select after reset");
        rd(7, 8'h00, "R1 flag after reset");
        chk("R1 irq after reset", {7'd0, irq_req}, 8'h00);

        // R2 R3 R6 R7 R11: per position, per polarity, both directions
        for (int i = 0; i < 8; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [7:0] bit_m;
                bit_m = 8'(1 << i);
                wr(6, pol ? bit_m : 8'h00);
                rd(6, pol ? (bit_m & IMPL) : 8'h00, "R7 select reserved");
                pins = pins | bit_m;
                tick(); tick();
                rd(7, 8'h00, "R11 not yet after two edges");
                tick();
                exp_flag = (pol == 0) ? (bit_m & IMPL) : 8'h00;
                rd(7, exp_flag, "R2 rising edge result");
                chk("R6 irq low with mask closed", {7'd0, irq_req}, 8'h00);
                wr(7, 8'hFF);
                rd(7, 8'h00, "R4 clear after rise");
                pins = pins & ~bit_m;
                tick(); tick(); tick();
                exp_flag = (pol == 1) ? (bit_m & IMPL) : 8'h00;
                rd(7, exp_flag, "R3 falling edge result");
                wr(7, 8'hFF);
                rd(7, 8'h00, "R4 clear after fall");
            end
        end

        // R9: polarity flips on steady pins
        wr(6, 8'h00);
        pins = 8'h15;
        repeat (4) tick();
        wr(7, 8'hFF);
        wr(6, 8'hFF); tick(); tick();
        wr(6, 8'h00); tick(); tick();
        wr(6, 8'h2A); tick(); tick();
        rd(7, 8'h00, "R9 no flag from polarity change");
        wr(6, 8'h00);
        pins = 8'h00;
        repeat (4) tick();
        wr(7, 8'hFF);

        // Build a flag pattern 0x25 with mask closed
        pins = 8'h25;
        repeat (3) tick();
        rd(7, 8'h25, "R6 flags set with mask closed");
        chk("R6 irq stays low", {7'd0, irq_req}, 8'h00);

        // R5 R7: sweep the whole enable space
        for (int en = 0; en < 256; en++) begin
            wr(5, 8'(en));
            rd(5, 8'(en) & IMPL, "R7 enable reserved");
            chk("R5 irq vs mask", {7'd0, irq_req},
                {7'd0, ((8'(en) & IMPL & 8'h25) != 8'h00)});
        end

        // R4: write-zero no effect, selective clear
        wr(5, 8'h3F);
        wr(7, 8'h00);
        rd(7, 8'h25, "R4 write zero keeps flags");
        wr(7, 8'h04);
        rd(7, 8'h21, "R4 selective clear");
        chk("R5 irq still up", {7'd0, irq_req}, 8'h01);
        wr(7, 8'h21);
        rd(7, 8'h00, "R4 all cleared");
        chk("R5 irq drops with flags", {7'd0, irq_req}, 8'h00);

        // R8: clear collides with a fresh edge on pin 1
        pins = pins | 8'h02;
        tick(); tick();
        wr(7, 8'h02);
        rd(7, 8'h02, "R8 edge beats clear");
        wr(7, 8'h02);
        rd(7, 8'h00, "R8 later clear works");

        // R10: other offsets inert
        wr(5, 8'h0F);
        wr(6, 8'h00);
        for (int a = 0; a < 16; a++) begin
            if (a != 5 && a != 6 && a != 7) begin
                wr(a, 8'hFF);
                rd(a, 8'h00, "R10 unused offset reads zero");
            end
        end
        rd(5, 8'h0F, "R10 enable untouched");
        rd(6, 8'h00, "R10 select untouched");
        rd(7, 8'h00, "R10 flags untouched");

        // R5: late enable with pending flag
        wr(5, 8'h00);
        pins = pins | 8'h08;
        repeat (3) tick();
        rd(7, 8'h08, "R6 pin3 flag pending");
        chk("R5 irq low before enable", {7'd0, irq_req}, 8'h00);
        wr(5, 8'h08);
        chk("R5 irq immediate on enable", {7'd0, irq_req}, 8'h01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule